// File: doc/BRIEF.md
# TCP/UDP Header Error Classifier

This block sits after the stage that finds the layer-4 header of an IPv4 or IPv6 packet. It receives the L4 bytes one per cycle, starting with the first header byte, and computes a 4-bit error code for the packet's work descriptor. It checks that the packet covers the whole header, that the L4 length agrees with the IP layer, that the checksum is correct, that neither port is zero, and that a TCP segment does not carry an illegal flag combination.

The sideband is presented together with the first byte. It gives the protocol, the L4 length implied by the IP header, and a checksum seed that already holds the one's-complement sum of the pseudo-header. One cycle after the last byte, the block raises a done flag and presents the code. Both stay unchanged until the next packet begins.

Top module: `l4_hdr_checker`

## Requirements
- R1: While reset is asserted and after it is released, `err_done` and `err_code` are 0.
- R2: `err_done` rises and `err_code` takes its value on the clock edge that accepts the byte marked `in_eop`. Both then hold until the next accepted `in_sop` byte. That byte clears `err_done` and sets the code to 0, unless the same byte also carries `in_eop`.
- R3: Code 1 is reported when a TCP packet has fewer than 20 bytes or a UDP packet has fewer than 8 bytes.
- R4: Code 3 is reported on a length mismatch. For TCP, the number of bytes received differs from `in_ip_len`. For UDP, the length field (bytes 4 and 5, most significant byte first) differs from `in_ip_len`.
- R5: Code 2 is reported when the checksum fails. The block forms the 16-bit one's-complement sum, with end-around carry, of the seed and all bytes taken as big-endian pairs. A byte at an even offset is the high byte, and an odd trailing byte is padded with a zero low byte. The check passes only when the sum is 0xFFFF.
- R6: For UDP, a checksum field of zero (bytes 6 and 7) disables the R5 check.
- R7: Code 4 is reported when the source port (bytes 0-1) or the destination port (bytes 2-3) is zero.
- R8: For TCP, the flags are byte 13, with FIN at bit 0, SYN at bit 1, RST at bit 2, PSH at bit 3, ACK at bit 4 and URG at bit 5. Bits 7:6 are ignored. Code 8 is reported when bits 5:0 equal 000001 (FIN only), and code 9 when bits 5:0 are all clear.
- R9: For TCP, the following codes apply whatever the other flags are: code 10 for FIN with RST, code 11 for SYN with URG, code 12 for SYN with RST, and code 13 for SYN with FIN.
- R10: When several conditions apply, the code reported is the first in this order: 1, 3, 2, 4, 8, 9, 10, 11, 12, 13. Flag codes are never reported for UDP.
- R11: Protocol and IP length are sampled only with the `in_sop` byte, and the seed is used only then. Sideband values on later bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sop | input | 1 | The byte is the first L4 byte |
| in_eop | input | 1 | The byte is the last L4 byte |
| in_byte | input | 8 | Packet byte |
| in_is_tcp | input | 1 | 1 for TCP, 0 for UDP (sampled at start) |
| in_ip_len | input | LEN_W | L4 length implied by the IP header (sampled at start) |
| in_seed | input | 16 | Pseudo-header one's-complement sum (used at start) |
| err_code | output | 4 | Error code of the last packet |
| err_done | output | 1 | Code is valid for the last packet |

## Verification
On every cycle, the assertions check how the done flag follows the start and end bytes. They also check that code and flag stay stable between packets, that only legal code values appear, and that no flag code ever follows a UDP packet. Whether a particular packet receives the right code can only be shown by the bench's scenarios. These cover truncation, length and checksum errors, skipping of a zero UDP checksum, zero ports, the six flag patterns, the priority between overlapping errors, and sideband changes in the middle of a packet.

// File: rtl/l4c_pkg.sv
package l4c_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [3:0] l4c_code_t;

  localparam l4c_code_t CODE_OK       = 4'd0;
  localparam l4c_code_t CODE_SHORT    = 4'd1;
  localparam l4c_code_t CODE_CSUM     = 4'd2;
  localparam l4c_code_t CODE_LEN      = 4'd3;
  localparam l4c_code_t CODE_PORT     = 4'd4;
  localparam l4c_code_t CODE_FIN_ONLY = 4'd8;
  localparam l4c_code_t CODE_NO_FLAG  = 4'd9;
  localparam l4c_code_t CODE_FIN_RST  = 4'd10;
  localparam l4c_code_t CODE_SYN_URG  = 4'd11;
  localparam l4c_code_t CODE_SYN_RST  = 4'd12;
  localparam l4c_code_t CODE_SYN_FIN  = 4'd13;

  // header sizes in bytes
  localparam int TCP_HDR_BYTES = 20;
  localparam int UDP_HDR_BYTES = 8;

  // byte offsets of fields that are decoded
  localparam int OFS_SRC_PORT  = 0;
  localparam int OFS_DST_PORT  = 2;
  localparam int OFS_UDP_LEN   = 4;
  localparam int OFS_UDP_CSUM  = 6;
  localparam int OFS_TCP_FLAGS = 13;

  // flag bit positions
  localparam int FB_FIN = 0;
  localparam int FB_SYN = 1;
  localparam int FB_RST = 2;
  localparam int FB_URG = 5;

  typedef struct packed {
    logic [WORD_W-1:0] src_port;
    logic [WORD_W-1:0] dst_port;
    logic [WORD_W-1:0] udp_len;
    logic [WORD_W-1:0] udp_csum;
    logic [BYTE_W-1:0] tcp_flags;
  } l4c_fields_t;

endpackage

// File: rtl/l4c_byte_track.sv
module l4c_byte_track
  import l4c_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [LEN_W-1:0]  offs,
  output logic [LEN_W-1:0]  cnt_nxt,
  output l4c_fields_t       fld_nxt
);

  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  l4c_fields_t      fld_q;
  logic [LEN_W-1:0] base_cnt;
  l4c_fields_t      base_fld;

  always_comb begin
    base_cnt = in_sop ? '0 : cnt_q;
    base_fld = in_sop ? '0 : fld_q;
    offs     = base_cnt;
    cnt_nxt  = base_cnt;
    fld_nxt  = base_fld;
    if (in_valid) begin
      cnt_nxt = (base_cnt == CNT_MAX) ? base_cnt : base_cnt + 1'b1;
      if (offs == LEN_W'(OFS_SRC_PORT))      fld_nxt.src_port[15:8] = in_byte;
      if (offs == LEN_W'(OFS_SRC_PORT + 1))  fld_nxt.src_port[7:0]  = in_byte;
      if (offs == LEN_W'(OFS_DST_PORT))      fld_nxt.dst_port[15:8] = in_byte;
      if (offs == LEN_W'(OFS_DST_PORT + 1))  fld_nxt.dst_port[7:0]  = in_byte;
      if (offs == LEN_W'(OFS_UDP_LEN))       fld_nxt.udp_len[15:8]  = in_byte;
      if (offs == LEN_W'(OFS_UDP_LEN + 1))   fld_nxt.udp_len[7:0]   = in_byte;
      if (offs == LEN_W'(OFS_UDP_CSUM))      fld_nxt.udp_csum[15:8] = in_byte;
      if (offs == LEN_W'(OFS_UDP_CSUM + 1))  fld_nxt.udp_csum[7:0]  = in_byte;
      if (offs == LEN_W'(OFS_TCP_FLAGS))     fld_nxt.tcp_flags      = in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fld_q <= '0;
    end else if (in_valid) begin
      cnt_q <= cnt_nxt;
      fld_q <= fld_nxt;
    end
  end

endmodule

// File: rtl/l4c_csum_acc.sv
module l4c_csum_acc
  import l4c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              odd_ofs,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [WORD_W-1:0] seed,
  output logic [WORD_W-1:0] acc_nxt
);

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] word;
  logic [WORD_W:0]   raw;

  always_comb begin
    base = in_sop ? seed : acc_q;
    // even offset is the high byte of a pair
    word = odd_ofs ? {{BYTE_W{1'b0}}, in_byte} : {in_byte, {BYTE_W{1'b0}}};
    raw  = {1'b0, base} + {1'b0, word};
    if (in_valid) acc_nxt = raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
    else          acc_nxt = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (in_valid) acc_q <= acc_nxt;
  end

endmodule

// File: rtl/l4c_classify.sv
module l4c_classify
  import l4c_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              is_tcp,
  input  logic [LEN_W-1:0]  ip_len,
  input  logic [LEN_W-1:0]  byte_cnt,
  input  l4c_fields_t       fld,
  input  logic [WORD_W-1:0] csum,
  output l4c_code_t         code
);

  localparam int CMP_W = (LEN_W > WORD_W) ? LEN_W : WORD_W;

  logic [CMP_W-1:0] need, cnt_w, ip_w, ulen_w;
  logic             short_hdr, len_bad, csum_bad, port_bad;
  logic [5:0]       fl;

  always_comb begin
    need      = is_tcp ? CMP_W'(TCP_HDR_BYTES) : CMP_W'(UDP_HDR_BYTES);
    cnt_w     = CMP_W'(byte_cnt);
    ip_w      = CMP_W'(ip_len);
    ulen_w    = CMP_W'(fld.udp_len);
    short_hdr = cnt_w < need;
    len_bad   = is_tcp ? (cnt_w != ip_w) : (ulen_w != ip_w);
    csum_bad  = (csum != {WORD_W{1'b1}}) && (is_tcp || (fld.udp_csum != '0));
    port_bad  = (fld.src_port == '0) || (fld.dst_port == '0);
    fl        = fld.tcp_flags[5:0];

    if (short_hdr)     code = CODE_SHORT;
    else if (len_bad)  code = CODE_LEN;
    else if (csum_bad) code = CODE_CSUM;
    else if (port_bad) code = CODE_PORT;
    else if (!is_tcp)  code = CODE_OK;
    else if (fl == 6'b000001)         code = CODE_FIN_ONLY;
    else if (fl == 6'b000000)         code = CODE_NO_FLAG;
    else if (fl[FB_FIN] && fl[FB_RST]) code = CODE_FIN_RST;
    else if (fl[FB_SYN] && fl[FB_URG]) code = CODE_SYN_URG;
    else if (fl[FB_SYN] && fl[FB_RST]) code = CODE_SYN_RST;
    else if (fl[FB_SYN] && fl[FB_FIN]) code = CODE_SYN_FIN;
    else                               code = CODE_OK;
  end

endmodule

// File: rtl/l4_hdr_checker.sv
module l4_hdr_checker
  import l4c_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_byte,
  input  logic             in_is_tcp,
  input  logic [LEN_W-1:0] in_ip_len,
  input  logic [15:0]      in_seed,
  output logic [3:0]       err_code,
  output logic             err_done
);

  logic             first;
  logic             tcp_q, tcp_eff;
  logic [LEN_W-1:0] len_q, len_eff;
  logic [LEN_W-1:0] offs, cnt_nxt;
  l4c_fields_t      fld_nxt;
  logic [WORD_W-1:0] acc_nxt;
  l4c_code_t        cls_code;
  l4c_code_t        code_q, code_d;
  logic             done_q, done_d;

  assign first   = in_valid && in_sop;
  assign tcp_eff = first ? in_is_tcp : tcp_q;
  assign len_eff = first ? in_ip_len : len_q;

  l4c_byte_track #(.LEN_W(LEN_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sop  (in_sop),
    .in_byte (in_byte),
    .offs    (offs),
    .cnt_nxt (cnt_nxt),
    .fld_nxt (fld_nxt)
  );

  l4c_csum_acc u_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sop  (in_sop),
    .odd_ofs (offs[0]),
    .in_byte (in_byte),
    .seed    (in_seed),
    .acc_nxt (acc_nxt)
  );

  l4c_classify #(.LEN_W(LEN_W)) u_cls (
    .is_tcp  (tcp_eff),
    .ip_len  (len_eff),
    .byte_cnt(cnt_nxt),
    .fld     (fld_nxt),
    .csum    (acc_nxt),
    .code    (cls_code)
  );

  // sideband capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcp_q <= 1'b0;
      len_q <= '0;
    end else if (first) begin
      tcp_q <= in_is_tcp;
      len_q <= in_ip_len;
    end
  end

  // result next state
  always_comb begin
    done_d = done_q;
    code_d = code_q;
    if (first) begin
      done_d = 1'b0;
      code_d = CODE_OK;
    end
    if (in_valid && in_eop) begin
      done_d = 1'b1;
      code_d = cls_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      code_q <= CODE_OK;
    end else if (in_valid) begin
      done_q <= done_d;
      code_q <= code_d;
    end
  end

  assign err_code = code_q;
  assign err_done = done_q;

endmodule

// File: rtl/l4c_checker.sv
module l4c_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sop,
  input logic       in_eop,
  input logic       in_is_tcp,
  input logic [3:0] err_code,
  input logic       err_done
);

  logic pkt_tcp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pkt_tcp <= 1'b0;
    else if (in_valid && in_sop) pkt_tcp <= in_is_tcp;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (err_code == 4'd0 && !err_done)
        else $error("outputs not clear in reset");
    end
  end

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop) |=> err_done);

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !in_eop) |=> (!err_done && err_code == 4'd0));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (in_sop || in_eop)) |=> ($stable(err_code) && $stable(err_done)));

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_done |-> (err_code inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4,
                                   4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13}));

  assert_udp_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_done && err_code >= 4'd8) |-> pkt_tcp);

endmodule

bind l4_hdr_checker l4c_checker u_l4c_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sop   (in_sop),
  .in_eop   (in_eop),
  .in_is_tcp(in_is_tcp),
  .err_code (err_code),
  .err_done (err_done)
);

// File: tb/l4_hdr_checker_test.sv
module l4_hdr_checker_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop, in_is_tcp;
  logic [7:0]  in_byte;
  logic [15:0] in_ip_len, in_seed;
  logic [3:0]  err_code;
  logic        err_done;

  int tests;
  int fails;
  int cycles;

  logic [7:0] pkt [64];

  l4_hdr_checker #(.LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_byte(in_byte), .in_is_tcp(in_is_tcp),
    .in_ip_len(in_ip_len), .in_seed(in_seed),
    .err_code(err_code), .err_done(err_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] osum(input int n, input logic [15:0] seed);
    logic [31:0] s;
    s = 32'(seed);
    for (int i = 0; i < n; i += 2) begin
      s = s + {16'd0, pkt[i], ((i + 1 < n) ? pkt[i+1] : 8'd0)};
    end
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [15:0] good_seed(input int n);
    return ~osum(n, 16'd0);
  endfunction

  function automatic logic [3:0] model(input bit tcp, input int n,
                                       input logic [15:0] iplen, input logic [15:0] seed);
    logic [5:0] f;
    if (n < (tcp ? 20 : 8)) return 4'd1;
    if (tcp ? (n != int'(iplen)) : ({pkt[4], pkt[5]} != iplen)) return 4'd3;
    if (osum(n, seed) != 16'hFFFF && (tcp || {pkt[6], pkt[7]} != 16'd0)) return 4'd2;
    if ({pkt[0], pkt[1]} == 16'd0 || {pkt[2], pkt[3]} == 16'd0) return 4'd4;
    if (!tcp) return 4'd0;
    f = pkt[13][5:0];
    if (f == 6'b000001) return 4'd8;
    if (f == 6'b000000) return 4'd9;
    if (f[0] && f[2]) return 4'd10;
    if (f[1] && f[5]) return 4'd11;
    if (f[1] && f[2]) return 4'd12;
    if (f[1] && f[0]) return 4'd13;
    return 4'd0;
  endfunction

  // clean packet: nonzero ports, ACK only, UDP length = n, nonzero checksum field
  task automatic mk(input bit tcp, input int n);
    for (int i = 0; i < 64; i++) pkt[i] = 8'(i * 7 + 3);
    pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h00; pkt[3] = 8'h50;
    if (tcp) pkt[13] = 8'h10;
    else begin
      pkt[4] = 8'(n >> 8); pkt[5] = 8'(n);
      pkt[6] = 8'hBE; pkt[7] = 8'hEF;
    end
  endtask

  task automatic send(input bit tcp, input int n, input logic [15:0] iplen,
                      input logic [15:0] seed, input bit gaps, input logic [3:0] exp,
                      input string req);
    logic [3:0] held;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) chk(int'(err_done), 0, "R2 done cleared by start");
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == n - 1);
      in_byte  = pkt[i];
      if (i == 0) begin
        in_is_tcp = tcp; in_ip_len = iplen; in_seed = seed;
      end else begin
        // R11: sideband changes after the start byte must not matter
        in_is_tcp = 1'($urandom); in_ip_len = 16'($urandom); in_seed = 16'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk(int'(err_done), 1, "R2 done after last byte");
    chk(int'(err_code), int'(exp), req);
    held = err_code;
    repeat (2) @(negedge clk);
    chk(int'(err_code), int'(held), "R2 code held");
    chk(int'(err_done), 1, "R2 done held");
  endtask

  initial begin
    tests = 0; fails = 0; cycles = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 0; in_sop = 0; in_eop = 0; in_byte = 0;
    in_is_tcp = 0; in_ip_len = 0; in_seed = 0;
    repeat (3) @(negedge clk);
    chk(int'(err_code), 0, "R1 code in reset");
    chk(int'(err_done), 0, "R1 done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(err_code), 0, "R1 code after reset");
    chk(int'(err_done), 0, "R1 done after reset");

    // directed
    mk(1, 24); send(1, 24, 16'd24, good_seed(24), 0, 4'd0, "R5 clean TCP");
    mk(0, 13); send(0, 13, 16'd13, good_seed(13), 0, 4'd0, "R5 clean UDP odd length");
    mk(1, 19); send(1, 19, 16'd19, good_seed(19), 0, 4'd1, "R3 TCP 19 bytes");
    mk(0, 7);  send(0, 7, 16'd7, good_seed(7), 0, 4'd1, "R3 UDP 7 bytes");
    mk(1, 1);  send(1, 1, 16'd1, 16'd0, 0, 4'd1, "R3 single byte packet");
    mk(1, 20); send(1, 20, 16'd21, good_seed(20), 0, 4'd3, "R4 TCP count mismatch");
    mk(0, 10); pkt[5] = 8'd11;
    send(0, 10, 16'd10, good_seed(10), 0, 4'd3, "R4 UDP length field mismatch");
    mk(1, 20); send(1, 20, 16'd20, good_seed(20) ^ 16'h0001, 0, 4'd2, "R5 TCP bad sum");
    mk(0, 8);  send(0, 8, 16'd8, good_seed(8) ^ 16'h0100, 0, 4'd2, "R5 UDP bad sum");
    mk(0, 8);  pkt[6] = 0; pkt[7] = 0;
    send(0, 8, 16'd8, 16'h1357, 0, 4'd0, "R6 UDP zero checksum skips");
    mk(1, 20); pkt[0] = 0; pkt[1] = 0;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd4, "R7 zero source port");
    mk(0, 8);  pkt[2] = 0; pkt[3] = 0;
    send(0, 8, 16'd8, good_seed(8), 0, 4'd4, "R7 zero destination port");
    mk(1, 20); pkt[13] = 8'hC1;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd8, "R8 FIN only, top bits ignored");
    mk(1, 20); pkt[13] = 8'h00;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd9, "R8 no flags");
    mk(1, 20); pkt[13] = 8'h15;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd10, "R9 FIN RST");
    mk(1, 20); pkt[13] = 8'h32;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd11, "R9 SYN URG");
    mk(1, 20); pkt[13] = 8'h06;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd12, "R9 SYN RST");
    mk(1, 20); pkt[13] = 8'h03;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd13, "R9 SYN FIN");
    mk(1, 20); pkt[13] = 8'h07;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd10, "R10 FIN RST before SYN RST");
    mk(1, 20); pkt[13] = 8'h00; pkt[2] = 0; pkt[3] = 0;
    send(1, 20, 16'd20, good_seed(20), 0, 4'd4, "R10 port before flags");
    mk(1, 20); send(1, 20, 16'd22, 16'd0, 0, 4'd3, "R10 length before checksum");
    mk(1, 20); pkt[0] = 0; pkt[1] = 0;
    send(1, 20, 16'd20, 16'd5, 0, 4'd2, "R10 checksum before port");
    mk(0, 8);  pkt[13] = 8'h00; pkt[12] = 8'h00;
    send(0, 8, 16'd8, good_seed(8), 0, 4'd0, "R10 UDP never flag code");
    mk(0, 20); pkt[13] = 8'h01;
    send(0, 20, 16'd20, good_seed(20), 1, 4'd0, "R11 UDP with gaps and sideband noise");

    // random
    for (int k = 0; k < 300; k++) begin
      bit tcp;
      int n;
      logic [15:0] iplen, seed;
      tcp = 1'($urandom);
      if ($urandom % 10 == 0) n = 1 + int'($urandom % (tcp ? 19 : 7));
      else n = (tcp ? 20 : 8) + int'($urandom % 21);
      for (int i = 0; i < 64; i++) pkt[i] = 8'($urandom);
      if ($urandom % 10 == 0) begin pkt[0] = 0; pkt[1] = 0; end
      if ($urandom % 10 == 0) begin pkt[2] = 0; pkt[3] = 0; end
      if (tcp && ($urandom % 2 == 0)) pkt[13] = 8'h10;
      iplen = 16'(n);
      if (!tcp) begin
        pkt[4] = 8'(n >> 8); pkt[5] = 8'(n);
        if ($urandom % 5 == 0) begin pkt[6] = 0; pkt[7] = 0; end
      end
      if ($urandom % 10 == 0) iplen = iplen + 16'd1;
      seed = ($urandom % 5 == 0) ? 16'($urandom) : good_seed(n);
      send(tcp, n, iplen, seed, 1, model(tcp, n, iplen, seed), "R10 random packet");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule